// File: doc/BRIEF.md
# Debug Halt and Resume Controller

This block sits next to a simple in-order hart and controls when the hart goes into Debug mode and when it comes back out. It holds the saved debug PC and a small debug status word, and it keeps the debug-mode flag.

A halt request from the debug module is taken on the next clock edge. On that edge the block records four things: where execution must restart, the reason for the halt, and the privilege and virtualization mode that were active. The restart address is the next instruction that has not yet run. If the instruction in flight has already retired, that is the following instruction. If it has not retired, that is the instruction itself, the same rule used for exception PCs on an interrupt.

A resume request in Debug mode produces a one-cycle redirect to the saved PC, together with the privilege and virtualization mode to restore. Debug software reads and writes the two registers over a plain CSR request port. Any such access outside Debug mode is reported as an illegal instruction and changes nothing. The CSR port has no handshake: a request is taken in the cycle that `csr_valid` is high. Read data and the illegal flag answer in that same cycle, and a write takes effect on the next edge. `saved_pc` and `saved_status` show the held registers to the hart at all times.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset, `debug_mode`, `redirect_valid`, `illegal_insn`, `csr_rdata`, `saved_pc` and `saved_status` are all 0.
- R2: When `halt_req` is high and the block is not in Debug mode, `debug_mode` is 1 from the next cycle. In the same cycle the status word takes cause 3 and the current `cur_prv` and `cur_virt`.
- R3: On halt entry with `inflight_retired`=1, the saved PC becomes `inflight_pc` + 4.
- R4: On halt entry with `inflight_retired`=0, the saved PC becomes `inflight_pc`.
- R5: A CSR request (`csr_valid`=1) outside Debug mode raises `illegal_insn` in the same cycle and returns `csr_rdata`=0. Neither register changes.
- R6: `halt_req` while already in Debug mode has no effect on either register or on `debug_mode`.
- R7: In Debug mode a write (`csr_write`=1) is visible from the next cycle. `csr_sel`=0 selects the saved PC and `csr_sel`=1 selects the status word. A write to the status word leaves its cause field unchanged.
- R8: In Debug mode a read returns the selected register in the same cycle with `illegal_insn`=0. The status word is returned zero-extended.
- R9: `resume_req` in Debug mode clears `debug_mode` on the next cycle. In that cycle `redirect_valid` pulses high for exactly one cycle, `redirect_pc` carries the saved PC, and `restore_prv`/`restore_virt` carry the saved fields. If a write arrives in the same cycle as the resume, the redirect uses the register value held before that write.
- R10: When `halt_req` and `resume_req` arrive together, halt wins outside Debug mode and resume wins inside Debug mode.
- R11: The status word is laid out as privilege in bits [1:0] (0 user, 1 supervisor, 3 machine), virtualization in bit [2] and cause in bits [5:3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_req | input | 1 | Halt request from the debug module |
| resume_req | input | 1 | Resume request from the debug module |
| cur_prv | input | 2 | Current privilege mode |
| cur_virt | input | 1 | Current virtualization mode |
| inflight_pc | input | XLEN | Address of the instruction in flight |
| inflight_retired | input | 1 | Instruction in flight has retired |
| csr_valid | input | 1 | CSR access request to a debug register |
| csr_write | input | 1 | Access is a write |
| csr_sel | input | 1 | 0 = saved PC, 1 = status word |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, same cycle |
| illegal_insn | output | 1 | Access outside Debug mode |
| debug_mode | output | 1 | Hart is in Debug mode |
| saved_pc | output | XLEN | Held debug PC |
| saved_status | output | 6 | Held status word |
| redirect_valid | output | 1 | One-cycle restart pulse |
| redirect_pc | output | XLEN | Restart address |
| restore_prv | output | 2 | Privilege mode to restore |
| restore_virt | output | 1 | Virtualization mode to restore |

## Verification
A wrong mode flag shows in the very next access, because reads and writes flip between legal and illegal and `illegal_insn` answers within the same cycle. A wrong capture or a lost write shows on `saved_pc` and `saved_status` one edge after it happens. On the restart path, the error carries over into `redirect_pc` and the restore fields on the edge after resume. The bench keeps its own model of both registers and the flag, and compares every output on every cycle, so a fault is reported in the cycle it first reaches a pin.

// File: rtl/dbg_hr_pkg.sv
package dbg_hr_pkg;
  localparam int STAT_W = 6;
  localparam logic [2:0] CAUSE_HALTREQ = 3'd3;

  typedef struct packed {
    logic [2:0] cause;
    logic       virt;
    logic [1:0] prv;
  } dstat_t;

  typedef enum logic {
    SEL_DPC   = 1'b0,
    SEL_DSTAT = 1'b1
  } csr_sel_e;
endpackage

// File: rtl/dbg_entry_capture.sv
module dbg_entry_capture
  import dbg_hr_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc,
  input  logic            retired,
  input  logic [1:0]      prv,
  input  logic            virt,
  output logic [XLEN-1:0] cap_pc,
  output dstat_t          cap_stat
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  always_comb begin
    cap_pc         = retired ? (pc + STEP) : pc;
    cap_stat.cause = CAUSE_HALTREQ;
    cap_stat.virt  = virt;
    cap_stat.prv   = prv;
  end
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_req,
  input  logic resume_req,
  output logic in_debug,
  output logic enter,
  output logic leave
);
  logic mode_q;

  always_comb begin
    enter = halt_req & ~mode_q;
    leave = resume_req & mode_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     mode_q <= 1'b0;
    else if (enter) mode_q <= 1'b1;
    else if (leave) mode_q <= 1'b0;
  end

  assign in_debug = mode_q;
endmodule

// File: rtl/dbg_csr_regs.sv
module dbg_csr_regs
  import dbg_hr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enter,
  input  logic [XLEN-1:0] cap_pc,
  input  dstat_t          cap_stat,
  input  logic            wr_en,
  input  csr_sel_e        wr_sel,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] dpc,
  output dstat_t          dstat
);
  logic [XLEN-1:0] dpc_q;
  dstat_t          dstat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dpc_q   <= '0;
      dstat_q <= '0;
    end else if (enter) begin
      dpc_q   <= cap_pc;
      dstat_q <= cap_stat;
    end else if (wr_en) begin
      if (wr_sel == SEL_DPC) begin
        dpc_q <= wr_data;
      end else begin
        dstat_q.virt <= wr_data[2];
        dstat_q.prv  <= wr_data[1:0];
      end
    end
  end

  assign dpc   = dpc_q;
  assign dstat = dstat_q;
endmodule

// File: rtl/dbg_redirect.sv
module dbg_redirect
  import dbg_hr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            leave,
  input  logic [XLEN-1:0] dpc,
  input  dstat_t          dstat,
  output logic            rd_valid,
  output logic [XLEN-1:0] rd_pc,
  output logic [1:0]      rd_prv,
  output logic            rd_virt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_pc    <= '0;
      rd_prv   <= '0;
      rd_virt  <= 1'b0;
    end else begin
      rd_valid <= leave;
      if (leave) begin
        rd_pc   <= dpc;
        rd_prv  <= dstat.prv;
        rd_virt <= dstat.virt;
      end
    end
  end
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_hr_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                halt_req,
  input  logic                resume_req,
  input  logic [1:0]          cur_prv,
  input  logic                cur_virt,
  input  logic [XLEN-1:0]     inflight_pc,
  input  logic                inflight_retired,
  input  logic                csr_valid,
  input  logic                csr_write,
  input  logic                csr_sel,
  input  logic [XLEN-1:0]     csr_wdata,
  output logic [XLEN-1:0]     csr_rdata,
  output logic                illegal_insn,
  output logic                debug_mode,
  output logic [STAT_W-1:0]   saved_status,
  output logic [XLEN-1:0]     saved_pc,
  output logic                redirect_valid,
  output logic [XLEN-1:0]     redirect_pc,
  output logic [1:0]          restore_prv,
  output logic                restore_virt
);
  localparam int PAD_W = XLEN - STAT_W;

  logic            in_dbg, enter, leave, wr_en;
  logic [XLEN-1:0] cap_pc, dpc;
  dstat_t          cap_stat, dstat;
  csr_sel_e        sel;

  dbg_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .resume_req(resume_req),
    .in_debug(in_dbg), .enter(enter), .leave(leave)
  );

  dbg_entry_capture #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_cap (
    .pc(inflight_pc), .retired(inflight_retired), .prv(cur_prv), .virt(cur_virt),
    .cap_pc(cap_pc), .cap_stat(cap_stat)
  );

  assign sel   = csr_sel_e'(csr_sel);
  assign wr_en = csr_valid & csr_write & in_dbg;

  dbg_csr_regs #(.XLEN(XLEN)) u_regs (
    .clk(clk), .rst_n(rst_n), .enter(enter), .cap_pc(cap_pc), .cap_stat(cap_stat),
    .wr_en(wr_en), .wr_sel(sel), .wr_data(csr_wdata), .dpc(dpc), .dstat(dstat)
  );

  dbg_redirect #(.XLEN(XLEN)) u_redir (
    .clk(clk), .rst_n(rst_n), .leave(leave), .dpc(dpc), .dstat(dstat),
    .rd_valid(redirect_valid), .rd_pc(redirect_pc),
    .rd_prv(restore_prv), .rd_virt(restore_virt)
  );

  always_comb begin
    illegal_insn = csr_valid & ~in_dbg;
    csr_rdata    = '0;
    if (csr_valid && in_dbg) begin
      csr_rdata = (sel == SEL_DSTAT) ? {{PAD_W{1'b0}}, dstat} : dpc;
    end
  end

  assign debug_mode   = in_dbg;
  assign saved_pc     = dpc;
  assign saved_status = dstat;
endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            halt_req,
  input logic            resume_req,
  input logic            csr_valid,
  input logic            csr_write,
  input logic            illegal_insn,
  input logic            debug_mode,
  input logic [5:0]      saved_status,
  input logic [XLEN-1:0] saved_pc,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_pc
);
  a_r2_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!debug_mode && halt_req) |=> (debug_mode && saved_status[5:3] == 3'd3));

  a_r5_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && !debug_mode) |-> illegal_insn);

  a_r5_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (!debug_mode && !halt_req) |=> ($stable(saved_pc) && $stable(saved_status)));

  a_r6_halt_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (debug_mode && halt_req && !(csr_valid && csr_write))
      |=> ($stable(saved_pc) && $stable(saved_status) && debug_mode == !$past(resume_req)));

  a_r7_cause_ro: assert property (@(posedge clk) disable iff (!rst_n)
    debug_mode |=> $stable(saved_status[5:3]));

  a_r9_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (debug_mode && resume_req) |=> (!debug_mode && redirect_valid && redirect_pc == $past(saved_pc)));

  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid);
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .resume_req(resume_req),
  .csr_valid(csr_valid), .csr_write(csr_write), .illegal_insn(illegal_insn),
  .debug_mode(debug_mode), .saved_status(saved_status), .saved_pc(saved_pc),
  .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
);

// File: tb/sim_dbg_halt_ctrl.sv
`timescale 1ns/1ps
module sim_dbg_halt_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, resume_req = 0, cur_virt = 0, inflight_retired = 0;
  logic csr_valid = 0, csr_write = 0, csr_sel = 0;
  logic [1:0] cur_prv = 0;
  logic [31:0] inflight_pc = 0, csr_wdata = 0;
  logic [31:0] csr_rdata, saved_pc, redirect_pc;
  logic [5:0] saved_status;
  logic illegal_insn, debug_mode, redirect_valid, restore_virt;
  logic [1:0] restore_prv;

  int checks = 0, fails = 0;

  // reference state
  bit m_dbg = 0, m_virt = 0, m_rv = 0, m_rvirt = 0;
  logic [31:0] m_dpc = 0, m_rpc = 0;
  logic [1:0] m_prv = 0, m_rprv = 0;
  logic [2:0] m_cause = 0;

  always #10 clk = ~clk;

  dbg_halt_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .resume_req(resume_req),
    .cur_prv(cur_prv), .cur_virt(cur_virt), .inflight_pc(inflight_pc),
    .inflight_retired(inflight_retired), .csr_valid(csr_valid), .csr_write(csr_write),
    .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .illegal_insn(illegal_insn), .debug_mode(debug_mode), .saved_status(saved_status),
    .saved_pc(saved_pc), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .restore_prv(restore_prv), .restore_virt(restore_virt)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_stat();
    return {26'd0, m_cause, m_virt, m_prv};
  endfunction

  task automatic cmp_state(string tag);
    chk(tag, "debug_mode", {31'd0, debug_mode}, {31'd0, m_dbg});
    chk(tag, "saved_pc", saved_pc, m_dpc);
    chk(tag, "saved_status", {26'd0, saved_status}, m_stat());
    chk(tag, "redirect_valid", {31'd0, redirect_valid}, {31'd0, m_rv});
    chk(tag, "redirect_pc", redirect_pc, m_rpc);
    chk(tag, "restore_prv", {30'd0, restore_prv}, {30'd0, m_rprv});
    chk(tag, "restore_virt", {31'd0, restore_virt}, {31'd0, m_rvirt});
  endtask

  // one cycle: drive after negedge, check combinational outputs, clock, update model, check registers
  task automatic cyc(string tag, logic h, logic r, logic [1:0] p, logic v,
                     logic [31:0] pc, logic ret, logic cv, logic cw, logic sel,
                     logic [31:0] wd);
    bit enter, leave;
    halt_req = h; resume_req = r; cur_prv = p; cur_virt = v;
    inflight_pc = pc; inflight_retired = ret;
    csr_valid = cv; csr_write = cw; csr_sel = sel; csr_wdata = wd;
    #2;
    chk(tag, "illegal_insn", {31'd0, illegal_insn}, {31'd0, cv && !m_dbg});
    chk(tag, "csr_rdata", csr_rdata, (cv && m_dbg) ? (sel ? m_stat() : m_dpc) : 32'd0);
    @(posedge clk);
    enter = h && !m_dbg;
    leave = r && m_dbg;
    m_rv = leave;
    if (leave) begin m_rpc = m_dpc; m_rprv = m_prv; m_rvirt = m_virt; end
    if (enter) begin
      m_dpc = ret ? pc + 32'd4 : pc;
      m_cause = 3'd3; m_prv = p; m_virt = v; m_dbg = 1;
    end else if (cv && cw && m_dbg) begin
      if (sel) begin m_prv = wd[1:0]; m_virt = wd[2]; end
      else m_dpc = wd;
    end
    if (leave) m_dbg = 0;
    @(negedge clk);
    cmp_state(tag);
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 2'd0, 0, 32'h0, 0, 0, 0, 0, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp_state("R1");
    chk("R1", "illegal_insn", {31'd0, illegal_insn}, 32'd0);
    chk("R1", "csr_rdata", csr_rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: access outside Debug mode is illegal and leaves registers alone
    cyc("R5", 0, 0, 2'd3, 0, 32'h40, 0, 1, 0, 0, 32'h0);
    cyc("R5", 0, 0, 2'd3, 0, 32'h40, 0, 1, 1, 0, 32'hDEAD0000);
    cyc("R5", 0, 0, 2'd3, 0, 32'h40, 0, 1, 1, 1, 32'h7);
    // R2 R3 R11: halt with retired instruction, supervisor, virt=1 -> pc+4, status 0x1D
    cyc("R3", 1, 0, 2'd1, 1, 32'h1000, 1, 0, 0, 0, 32'h0);
    chk("R11", "status layout", {26'd0, saved_status}, 32'h1D);
    chk("R3", "pc+4", saved_pc, 32'h1004);
    // R8: reads in Debug mode
    cyc("R8", 0, 0, 2'd0, 0, 32'h0, 0, 1, 0, 0, 32'h0);
    cyc("R8", 0, 0, 2'd0, 0, 32'h0, 0, 1, 0, 1, 32'h0);
    // R6: halt while halted has no effect
    cyc("R6", 1, 0, 2'd3, 0, 32'h5550, 1, 0, 0, 0, 32'h0);
    cyc("R6", 1, 0, 2'd0, 1, 32'h5554, 0, 0, 0, 0, 32'h0);
    // R7: writes visible next cycle, cause read-only
    cyc("R7", 0, 0, 2'd0, 0, 32'h0, 0, 1, 1, 0, 32'h2000);
    cyc("R7", 0, 0, 2'd0, 0, 32'h0, 0, 1, 1, 1, 32'hFF);
    chk("R7", "cause kept", {26'd0, saved_status}, 32'h1F);
    cyc("R8", 0, 0, 2'd0, 0, 32'h0, 0, 1, 0, 1, 32'h0);
    // R10 R9: resume wins while halted; a same-cycle write does not alter the redirect
    cyc("R10", 1, 1, 2'd0, 0, 32'h9990, 1, 1, 1, 0, 32'h2468);
    chk("R9", "redirect pc", redirect_pc, 32'h2000);
    chk("R9", "restore prv", {30'd0, restore_prv}, 32'd3);
    idle("R9");
    chk("R9", "pulse ends", {31'd0, redirect_valid}, 32'd0);
    // R5: write outside after resume, saved pc must stay
    cyc("R5", 0, 0, 2'd0, 0, 32'h0, 0, 1, 1, 0, 32'hBAD0);
    chk("R5", "pc kept", saved_pc, 32'h2468);
    // R10 R4: halt wins when running; not retired -> own pc
    cyc("R4", 1, 1, 2'd0, 0, 32'h3000, 0, 0, 0, 0, 32'h0);
    chk("R4", "own pc", saved_pc, 32'h3000);
    chk("R10", "halt wins", {31'd0, debug_mode}, 32'd1);
    idle("R8");
    cyc("R9", 0, 1, 2'd1, 1, 32'h0, 0, 0, 0, 0, 32'h0);
    chk("R9", "redirect pc user", redirect_pc, 32'h3000);
    idle("R9");
    idle("R1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule